// File: doc/BRIEF.md
# Ethernet Frame Transmit Encapsulator (100 Mb/s symbol stream)

This block turns a frame request into a continuous byte-wide symbol stream for a 100 Mb/s link. A request carries the destination address, source address, length/type word and a per-frame pad-disable flag on a valid/ready handshake. The payload follows on a separate byte stream with its own valid/ready and an end marker. The block adds the start code, the preamble, the start delimiter, the three header fields, the payload with optional zero padding and a 32-bit frame check sequence. It closes the frame with an end code. Every output cycle carries one symbol. A 2-bit kind field tags the symbol as a data byte or as one of three control codes.

Line coding, scrambling, deferral and collision handling belong to the stages that follow and are not part of this block. The block pulls a payload byte in each cycle that it shows payload-ready. The payload source must keep its valid signal high for the whole payload. In a payload cycle where valid is low, the block sends a zero byte and counts that byte as payload.

Top module: `tx_encap`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sym_kind` is IDLE (code 1), `sym_byte` is 0 and `req_ready` is high. Kind codes: DATA=0, IDLE=1, JK=2, TR=3.
- R2: A request is taken in the cycle where `req_valid` and `req_ready` are both high. The next cycle emits JK (code 2). Six DATA bytes of value 0x55 follow, then one DATA byte 0xD5.
- R3: After 0xD5 come the header fields, 14 DATA bytes in total. First the destination address, most significant byte (`req_dst[47:40]`) first. Then the source address in the same byte order. Then the length/type word, high byte first.
- R4: The payload follows the header one byte per cycle. `pay_ready` is high only in payload cycles and in drain cycles (R9). Each accepted byte appears on `sym_byte` in the same cycle. The byte taken with `pay_last` high is the last payload byte.
- R5: With `req_nopad` low, a payload shorter than 46 bytes is followed by zero bytes until the payload and pad together reach 46 bytes. A payload of 46 bytes or more gets no pad.
- R6: With `req_nopad` high at acceptance, no pad byte is inserted, whatever the payload length.
- R7: Four DATA bytes follow the payload (or the pad). They are the bitwise complement of a CRC-32 computed over every byte from the first destination byte through the last pad byte. The CRC uses polynomial 0x04C11DB7, is processed least significant bit first, starts from all ones, and is sent least significant byte first.
- R8: A TR symbol (code 3) follows the last check byte directly. `req_ready` stays low from acceptance through the TR cycle and returns high afterwards, unless R9 applies.
- R9: If the payload reaches 1500 bytes without `pay_last`, the payload ends there and the check bytes follow. `trunc_err` is high exactly in that frame's TR cycle. After TR the block shows IDLE with `pay_ready` high and discards bytes until one arrives with `pay_last`. Only then does `req_ready` return high.
- R10: A payload of exactly 1500 bytes that ends with `pay_last` is sent in full, with `trunc_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Block can take a new request |
| req_dst | input | 48 | Destination address |
| req_src | input | 48 | Source address |
| req_lentype | input | 16 | Length/type word |
| req_nopad | input | 1 | Disable minimum-size padding for this frame |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Block takes a payload byte this cycle |
| pay_data | input | 8 | Payload byte |
| pay_last | input | 1 | Marks the final payload byte |
| sym_kind | output | 2 | Symbol kind: 0 DATA, 1 IDLE, 2 JK, 3 TR |
| sym_byte | output | 8 | Data byte (0 for control symbols) |
| trunc_err | output | 1 | High in the TR cycle of a truncated frame |

## Verification
The bench targets payloads of 1, 45, 46 and 47 bytes around the pad threshold. A wrong comparison there shows up as one pad byte too many or too few, and as a check sequence that no longer matches. Short frames with padding disabled catch a design that pads anyway. Payloads of exactly 1500 and 1503 bytes separate a clean maximum frame from a truncated one. A design that is off by one at the limit either flags a legal frame or sends a 1501st byte. A design that skips the drain step leaves stale bytes to corrupt the next frame, and the bench catches that on the frame that follows. The check bytes are compared against an independent bit-serial CRC. A wrong byte order, a missing complement or a CRC that leaves out the pad bytes all fail that comparison.

// File: rtl/tx_encap_pkg.sv
package tx_encap_pkg;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RPOLY = 32'hEDB8_8320;
    localparam int          PRE_LEN   = 6;
    localparam int          HDR_LEN   = 14;
    localparam int          FCS_LEN   = 4;

    typedef enum logic [1:0] {
        SYM_DATA = 2'd0,
        SYM_IDLE = 2'd1,
        SYM_JK   = 2'd2,
        SYM_TR   = 2'd3
    } sym_kind_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_JK, PH_PRE, PH_SFD, PH_HDR,
        PH_PAY, PH_PAD, PH_FCS, PH_TR, PH_DRAIN
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [3:0] sub;
    } tx_sel_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++)
            r = r[0] ? ((r >> 1) ^ CRC_RPOLY) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/tx_encap_seq.sv
module tx_encap_seq
    import tx_encap_pkg::*;
#(
    parameter int MIN_PAY = 46,
    parameter int MAX_PAY = 1500
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_nopad,
    input  logic    pay_valid,
    input  logic    pay_last,
    output logic    req_ready,
    output logic    pay_ready,
    output logic    accept,
    output logic    crc_en,
    output tx_sel_t sel,
    output logic    trunc_err
);
    localparam int CW = $clog2(MAX_PAY + 1);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_PAY);
    localparam logic [CW-1:0] LAST_C = CW'(MAX_PAY - 1);

    phase_e        phase_q;
    logic [3:0]    sub_q;
    logic [CW-1:0] cnt_q;
    logic          nopad_q, err_q;
    logic          end_mark;

    assign end_mark  = pay_valid && pay_last;
    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign pay_ready = (phase_q == PH_PAY) || (phase_q == PH_DRAIN);
    assign crc_en    = (phase_q == PH_HDR) || (phase_q == PH_PAY) || (phase_q == PH_PAD);
    assign trunc_err = (phase_q == PH_TR) && err_q;
    assign sel       = '{phase: phase_q, sub: sub_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sub_q   <= '0;
            cnt_q   <= '0;
            nopad_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (req_valid) begin
                    phase_q <= PH_JK;
                    nopad_q <= req_nopad;
                    err_q   <= 1'b0;
                    cnt_q   <= '0;
                end
                PH_JK: begin
                    phase_q <= PH_PRE;
                    sub_q   <= '0;
                end
                PH_PRE: begin
                    sub_q <= sub_q + 4'd1;
                    if (sub_q == 4'(PRE_LEN - 1)) phase_q <= PH_SFD;
                end
                PH_SFD: begin
                    phase_q <= PH_HDR;
                    sub_q   <= '0;
                end
                PH_HDR: begin
                    sub_q <= sub_q + 4'd1;
                    if (sub_q == 4'(HDR_LEN - 1)) phase_q <= PH_PAY;
                end
                PH_PAY: begin
                    cnt_q <= cnt_q + 1'b1;
                    sub_q <= '0;
                    if (end_mark)
                        phase_q <= ((cnt_q + 1'b1) < MIN_C && !nopad_q) ? PH_PAD : PH_FCS;
                    else if (cnt_q == LAST_C) begin
                        phase_q <= PH_FCS;
                        err_q   <= 1'b1;
                    end
                end
                PH_PAD: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == MIN_C - 1'b1) phase_q <= PH_FCS;
                end
                PH_FCS: begin
                    sub_q <= sub_q + 4'd1;
                    if (sub_q == 4'(FCS_LEN - 1)) phase_q <= PH_TR;
                end
                PH_TR:    phase_q <= err_q ? PH_DRAIN : PH_IDLE;
                PH_DRAIN: if (end_mark) phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_PAY));

    // R4
    hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && pay_ready));

    // R5
    pad_reach_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PAD) |-> (cnt_q < MIN_C));

endmodule

// File: rtl/tx_encap_crc.sv
module tx_encap_crc
    import tx_encap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_SEED;
        else if (en)      crc <= crc_step(crc, din);
    end

    // R7
    crc_seed_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (crc == CRC_SEED));

    // R7
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !en) |=> $stable(crc));

endmodule

// File: rtl/tx_encap_field.sv
module tx_encap_field
    import tx_encap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [47:0] dst,
    input  logic [47:0] src,
    input  logic [15:0] lentype,
    input  tx_sel_t     sel,
    input  logic        pay_valid,
    input  logic [7:0]  pay_data,
    input  logic [31:0] crc,
    output sym_kind_e   kind,
    output logic [7:0]  byte_o
);
    logic [8*HDR_LEN-1:0] hdr_q;
    logic [6:0]           hsh;
    logic [31:0]          fcs;

    always_ff @(posedge clk) begin
        if (rst)       hdr_q <= '0;
        else if (load) hdr_q <= {dst, src, lentype};
    end

    assign hsh = 7'(8 * (HDR_LEN - 1 - int'(sel.sub)));
    assign fcs = ~crc;

    always_comb begin
        kind   = SYM_DATA;
        byte_o = 8'h00;
        unique case (sel.phase)
            PH_JK:  kind = SYM_JK;
            PH_TR:  kind = SYM_TR;
            PH_PRE: byte_o = PRE_BYTE;
            PH_SFD: byte_o = SFD_BYTE;
            PH_HDR: byte_o = hdr_q[hsh +: 8];
            PH_PAY: byte_o = pay_valid ? pay_data : 8'h00;
            PH_PAD: byte_o = 8'h00;
            PH_FCS: byte_o = fcs[{sel.sub[1:0], 3'b000} +: 8];
            default: kind  = SYM_IDLE;
        endcase
    end

endmodule

// File: rtl/tx_encap.sv
module tx_encap
    import tx_encap_pkg::*;
#(
    parameter int MIN_PAY = 46,
    parameter int MAX_PAY = 1500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [47:0] req_dst,
    input  logic [47:0] req_src,
    input  logic [15:0] req_lentype,
    input  logic        req_nopad,
    input  logic        pay_valid,
    output logic        pay_ready,
    input  logic [7:0]  pay_data,
    input  logic        pay_last,
    output logic [1:0]  sym_kind,
    output logic [7:0]  sym_byte,
    output logic        trunc_err
);
    tx_sel_t     sel;
    logic        accept, crc_en;
    logic [31:0] crc;
    sym_kind_e   kind;

    tx_encap_seq #(.MIN_PAY(MIN_PAY), .MAX_PAY(MAX_PAY)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_nopad(req_nopad),
        .pay_valid(pay_valid), .pay_last(pay_last), .req_ready(req_ready),
        .pay_ready(pay_ready), .accept(accept), .crc_en(crc_en),
        .sel(sel), .trunc_err(trunc_err)
    );

    tx_encap_crc u_crc (
        .clk(clk), .rst(rst), .clear(accept), .en(crc_en),
        .din(sym_byte), .crc(crc)
    );

    tx_encap_field u_field (
        .clk(clk), .rst(rst), .load(accept), .dst(req_dst), .src(req_src),
        .lentype(req_lentype), .sel(sel), .pay_valid(pay_valid),
        .pay_data(pay_data), .crc(crc), .kind(kind), .byte_o(sym_byte)
    );

    assign sym_kind = kind;

    // R1
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sym_kind == SYM_IDLE));

    // R2
    jk_then_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_kind == SYM_JK) |=> (sym_kind == SYM_DATA && sym_byte == PRE_BYTE));

    // R2
    accept_jk_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (sym_kind == SYM_JK));

    // R8
    tr_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_kind == SYM_TR) |=> (sym_kind == SYM_IDLE));

    // R9
    err_on_tr_chk: assert property (@(posedge clk) disable iff (rst)
        trunc_err |-> (sym_kind == SYM_TR));

endmodule

// File: tb/tx_encap_test.sv
module tx_encap_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_dst = '0;
    logic [47:0] req_src = '0;
    logic [15:0] req_lentype = '0;
    logic        req_nopad = 1'b0;
    logic        pay_valid = 1'b0;
    logic        pay_ready;
    logic [7:0]  pay_data = '0;
    logic        pay_last = 1'b0;
    logic [1:0]  sym_kind;
    logic [7:0]  sym_byte;
    logic        trunc_err;

    int checks = 0;
    int fails  = 0;

    logic [7:0] pay_mem [0:2047];
    logic [9:0] rec     [0:2047];
    logic [9:0] expv    [0:2047];

    always #4 clk = ~clk;

    tx_encap uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dst(req_dst), .req_src(req_src), .req_lentype(req_lentype),
        .req_nopad(req_nopad), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .pay_data(pay_data), .pay_last(pay_last), .sym_kind(sym_kind),
        .sym_byte(sym_byte), .trunc_err(trunc_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n, input int start);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ expv[start + i][b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        return ~c;
    endfunction

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int i = lo; i < hi; i++)
            if (rec[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, tag, int'(rec[first]), int'(expv[first]));
    endtask

    task automatic run_frame(input int len, input bit nopad);
        int n, body, k, idx, nsym, guard;
        logic [47:0] d, s;
        logic [15:0] lt;
        logic [31:0] f;
        bit seen_tr, done, busy_ok, err_seen, drain_ok;
        string btag;

        d  = {$urandom, $urandom};
        s  = {$urandom, $urandom};
        lt = 16'($urandom);
        for (int i = 0; i < len; i++) pay_mem[i] = 8'($urandom);

        // expected stream
        n = (len > 1500) ? 1500 : len;
        body = (!nopad && n < 46) ? 46 : n;
        k = 0;
        expv[k++] = {2'd2, 8'h00};
        for (int i = 0; i < 6; i++) expv[k++] = {2'd0, 8'h55};
        expv[k++] = {2'd0, 8'hD5};
        for (int i = 5; i >= 0; i--) expv[k++] = {2'd0, d[8*i +: 8]};
        for (int i = 5; i >= 0; i--) expv[k++] = {2'd0, s[8*i +: 8]};
        expv[k++] = {2'd0, lt[15:8]};
        expv[k++] = {2'd0, lt[7:0]};
        for (int i = 0; i < body; i++) expv[k++] = {2'd0, (i < n) ? pay_mem[i] : 8'h00};
        f = ref_crc(14 + body, 8);
        for (int i = 0; i < 4; i++) expv[k++] = {2'd0, f[8*i +: 8]};
        expv[k++] = {2'd3, 8'h00};

        // request
        @(negedge clk);
        req_valid = 1'b1; req_dst = d; req_src = s; req_lentype = lt; req_nopad = nopad;
        #1;
        check(req_ready === 1'b1 && sym_kind === 2'd1, "R1 idle/ready before frame",
              int'({req_ready, sym_kind}), 'h5);
        @(negedge clk);
        req_valid = 1'b0;

        idx = 0; nsym = 0; guard = 0;
        seen_tr = 0; done = 0; busy_ok = 1; err_seen = 0; drain_ok = 1;
        while (!done && guard < 4000) begin
            guard++;
            pay_valid = pay_ready;
            pay_data  = pay_mem[idx];
            pay_last  = (idx == len - 1);
            #1;
            if (!seen_tr) begin
                rec[nsym] = {sym_kind, sym_byte};
                nsym++;
                if (req_ready) busy_ok = 0;
                if (sym_kind == 2'd3) begin
                    seen_tr = 1;
                    err_seen = trunc_err;
                end else if (trunc_err) err_seen = 1'b1 ^ (len > 1500);
            end else begin
                if (sym_kind !== 2'd1) drain_ok = 0;
                if (req_ready && !pay_ready) done = 1;
            end
            if (pay_ready && pay_valid) idx++;
            @(negedge clk);
        end
        pay_valid = 1'b0;
        pay_last  = 1'b0;

        check(nsym == k, "R4 symbol count of frame", nsym, k);
        cmp_range(0, 8, "R2 start code, preamble, delimiter");
        cmp_range(8, 22, "R3 header byte order");
        btag = nopad ? "R6 payload without pad" : "R5 payload with pad";
        if (n >= 46 || nopad) btag = "R4 payload passthrough";
        cmp_range(22, 22 + body, btag);
        cmp_range(22 + body, 26 + body, "R7 check sequence");
        check(rec[k-1] === 10'h300, "R8 end code after check bytes", int'(rec[k-1]), 'h300);
        check(busy_ok, "R8 req_ready low during frame", busy_ok, 1);
        check(err_seen == (len > 1500), (len == 1500) ? "R10 no error at 1500" : "R9 trunc flag",
              err_seen, (len > 1500));
        if (len > 1500) begin
            check(drain_ok && idx == len, "R9 drain consumes rest with IDLE", idx, len);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(sym_kind === 2'd1 && sym_byte === 8'h00, "R1 reset symbol IDLE",
              int'({sym_kind, sym_byte}), 'h100);
        check(req_ready === 1'b1 && pay_ready === 1'b0 && trunc_err === 1'b0,
              "R1 reset handshake state", int'({req_ready, pay_ready, trunc_err}), 'h4);

        run_frame(46, 1'b0);
        run_frame(1, 1'b0);
        run_frame(45, 1'b0);
        run_frame(47, 1'b0);
        run_frame(10, 1'b1);
        run_frame(1, 1'b1);
        run_frame(1500, 1'b0);
        run_frame(1503, 1'b0);
        run_frame(20, 1'b0);
        for (int r = 0; r < 10; r++)
            run_frame(1 + int'($urandom_range(0, 119)), 1'($urandom));

        repeat (2) @(negedge clk);
        #1;
        check(sym_kind === 2'd1 && req_ready === 1'b1, "R1 idle after frames",
              int'({req_ready, sym_kind}), 'h5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule